// File: doc/BRIEF.md
# Timestamp Record Text-Line Serializer

This block takes 64-bit measurement records from a show-ahead FIFO and prints each one as a line of text on an asynchronous serial output. A record holds a seven-digit packed-BCD timestamp and a 32-bit channel bitmap. The block turns these into sixteen ASCII characters: the timestamp digits in decimal, the bitmap in upper-case hexadecimal, and a carriage return at the end. No processor is involved.

The serial output uses 8N1 framing. A counter divides the system clock down to the bit rate. With a 10 MHz clock and the default divider of 1042, the rate is about 9600 baud. That rate carries a peak of 32 lines per second with room to spare. Record layout: bits [31:0] hold the bitmap, bits [59:32] hold the timestamp with its most significant digit in [59:56], and bits [63:60] are not used. The FIFO shows its head word on `fifoData` whenever `fifoEmpty` is low. A one-cycle `fifoPop` takes that word and advances the FIFO.

Top module: `ts_line_serializer`

## Requirements
- R1: While the FIFO is empty and no line is in progress, `txOut` stays high and `fifoPop` stays low. `fifoPop` is never asserted while `fifoEmpty` is high.
- R2: Each popped record gives exactly sixteen characters. The sixteenth character is a carriage return, 0x0D.
- R3: Characters 1 to 7 are the timestamp digits, most significant digit first. Each character is 0x30 plus the digit value.
- R4: Characters 8 to 15 are the bitmap nibbles, most significant nibble first. Values 0 to 9 map to 0x30 to 0x39, and values 10 to 15 map to 0x41 to 0x46.
- R5: Each character is sent as one frame: a low start bit, eight data bits with the LSB first, and a high stop bit. Every bit lasts exactly CLKS_PER_BIT clocks.
- R6: `fifoPop` is a single-cycle pulse. It is only raised once the stop bit of the previous carriage return has ended. At that point, every line already popped has been fully sent.
- R7: Bits [63:60] of the record have no effect on the line.
- R8: The record is captured on the pop cycle. Later changes on `fifoData` do not alter the line in progress.
- R9: Timestamp nibbles are not range-checked. A nibble value v from 10 to 15 is sent as 0x30+v (0x3A to 0x3F).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEmpty | input | 1 | High when the FIFO holds no record |
| fifoData | input | 64 | Head record of the FIFO (show-ahead) |
| fifoPop | output | 1 | One-cycle pulse that takes the head record |
| txOut | output | 1 | Serial output, idles high |

## Verification
The bench builds the block with CLKS_PER_BIT set to 8 and keeps the default seven timestamp digits and eight bitmap nibbles. The short bit period means dozens of complete lines, both back-to-back bursts and isolated records, fit in a short run. Each frame is sampled on every clock, so the exact width of each bit and the gaps between frames can be checked. With the default line shape, every character position is exercised, including timestamp nibbles above nine and unused top bits carrying random values.

// File: rtl/ts_line_pkg.sv
package ts_line_pkg;

  typedef struct packed {
    logic loadRec;     // capture head record, reset character index
    logic startFrame;  // start sending the current character
    logic advance;     // step to the next character
  } lineCtl_t;

  localparam logic [7:0] CR_CHAR = 8'h0D;
  localparam logic [3:0] DEC_HI  = 4'h3;

  function automatic logic [7:0] nibToHex(input logic [3:0] n);
    logic [7:0] c;
    if (n < 4'd10) c = {4'h3, n};
    else           c = 8'h37 + {4'h0, n};
    return c;
  endfunction

endpackage

// File: rtl/ts_char_builder.sv
module ts_char_builder
  import ts_line_pkg::*;
#(
  parameter int TS_DIGITS   = 7,
  parameter int MAP_NIBBLES = 8,
  parameter int LINE_LEN    = TS_DIGITS + MAP_NIBBLES + 1,
  parameter int IDX_W       = $clog2(LINE_LEN),
  parameter int USED_W      = 4 * (TS_DIGITS + MAP_NIBBLES)
) (
  input  logic [USED_W-1:0] rec,
  input  logic [IDX_W-1:0]  idx,
  output logic [7:0]        charOut
);

  localparam int MAP_W = 4 * MAP_NIBBLES;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_LEN - 1);

  logic [7:0] charTab [LINE_LEN];

  genvar i;
  generate
    for (i = 0; i < TS_DIGITS; i++) begin : g_ts
      assign charTab[i] = {DEC_HI, rec[MAP_W + 4*(TS_DIGITS-1-i) +: 4]};
    end
    for (i = 0; i < MAP_NIBBLES; i++) begin : g_map
      assign charTab[TS_DIGITS + i] = nibToHex(rec[4*(MAP_NIBBLES-1-i) +: 4]);
    end
  endgenerate
  assign charTab[LINE_LEN-1] = CR_CHAR;

  always_comb begin
    if (idx <= LAST_IDX) charOut = charTab[idx];
    else                 charOut = CR_CHAR;
  end

endmodule

// File: rtl/ts_uart_tx.sv
module ts_uart_tx #(
  parameter int CLKS_PER_BIT = 1042,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startFrame,
  input  logic [DATA_BITS-1:0] dataIn,
  output logic                 txOut,
  output logic                 txActive,
  output logic                 frameDone
);

  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int BAUD_W     = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int LEFT_W     = $clog2(FRAME_BITS + 1);
  localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(CLKS_PER_BIT - 1);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [BAUD_W-1:0]     baudCnt;
  logic [LEFT_W-1:0]     bitsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '1;
      baudCnt   <= '0;
      bitsLeft  <= '0;
      txActive  <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (startFrame) begin
        shiftReg <= {1'b1, dataIn, 1'b0};
        baudCnt  <= '0;
        bitsLeft <= LEFT_W'(FRAME_BITS);
        txActive <= 1'b1;
      end else if (txActive) begin
        if (baudCnt == BAUD_LAST) begin
          baudCnt <= '0;
          if (bitsLeft == LEFT_W'(1)) begin
            txActive  <= 1'b0;
            frameDone <= 1'b1;
          end else begin
            shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
            bitsLeft <= bitsLeft - 1'b1;
          end
        end else begin
          baudCnt <= baudCnt + 1'b1;
        end
      end
    end
  end

  // Shifted-in ones leave the stop level in bit 0 once the frame ends.
  assign txOut = shiftReg[0];

endmodule

// File: rtl/ts_line_datapath.sv
module ts_line_datapath
  import ts_line_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1042,
  parameter int TS_DIGITS    = 7,
  parameter int MAP_NIBBLES  = 8,
  parameter int REC_W        = 64,
  parameter int LINE_LEN     = TS_DIGITS + MAP_NIBBLES + 1,
  parameter int IDX_W        = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lineCtl_t         ctl,
  input  logic [REC_W-1:0] fifoData,
  output logic             txOut,
  output logic             txActive,
  output logic             frameDone,
  output logic             lastChar,
  output logic [IDX_W-1:0] charIdx
);

  localparam int USED_W = 4 * (TS_DIGITS + MAP_NIBBLES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_LEN - 1);

  logic [USED_W-1:0] recReg;
  logic [7:0]        curChar;

  generate
    if (REC_W > USED_W) begin : g_spare
      logic unusedSpareBits;
      assign unusedSpareBits = ^fifoData[REC_W-1:USED_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recReg  <= '0;
      charIdx <= '0;
    end else if (ctl.loadRec) begin
      recReg  <= fifoData[USED_W-1:0];
      charIdx <= '0;
    end else if (ctl.advance) begin
      charIdx <= charIdx + 1'b1;
    end
  end

  assign lastChar = (charIdx == LAST_IDX);

  ts_char_builder #(
    .TS_DIGITS  (TS_DIGITS),
    .MAP_NIBBLES(MAP_NIBBLES),
    .LINE_LEN   (LINE_LEN),
    .IDX_W      (IDX_W),
    .USED_W     (USED_W)
  ) u_chars (
    .rec    (recReg),
    .idx    (charIdx),
    .charOut(curChar)
  );

  ts_uart_tx #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_BITS   (8)
  ) u_tx (
    .clk       (clk),
    .rstN      (rstN),
    .startFrame(ctl.startFrame),
    .dataIn    (curChar),
    .txOut     (txOut),
    .txActive  (txActive),
    .frameDone (frameDone)
  );

endmodule

// File: rtl/ts_line_ctrl.sv
module ts_line_ctrl
  import ts_line_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fifoEmpty,
  input  logic     frameDone,
  input  logic     lastChar,
  output lineCtl_t ctl
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} lineState_t;

  lineState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      S_IDLE: begin
        if (!fifoEmpty) begin
          ctl.loadRec = 1'b1;
          stateNxt    = S_SEND;
        end
      end
      S_SEND: begin
        ctl.startFrame = 1'b1;
        stateNxt       = S_WAIT;
      end
      S_WAIT: begin
        if (frameDone) begin
          if (lastChar) begin
            stateNxt = S_IDLE;
          end else begin
            ctl.advance = 1'b1;
            stateNxt    = S_SEND;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/ts_line_serializer.sv
module ts_line_serializer
  import ts_line_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1042,
  parameter int TS_DIGITS    = 7,
  parameter int MAP_NIBBLES  = 8,
  parameter int REC_W        = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEmpty,
  input  logic [REC_W-1:0] fifoData,
  output logic             fifoPop,
  output logic             txOut
);

  localparam int LINE_LEN = TS_DIGITS + MAP_NIBBLES + 1;
  localparam int IDX_W    = $clog2(LINE_LEN);

  lineCtl_t         ctl;
  logic             frameDone;
  logic             lastChar;
  logic             txActive;
  logic [IDX_W-1:0] charIdx;

  ts_line_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fifoEmpty(fifoEmpty),
    .frameDone(frameDone),
    .lastChar (lastChar),
    .ctl      (ctl)
  );

  ts_line_datapath #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .TS_DIGITS   (TS_DIGITS),
    .MAP_NIBBLES (MAP_NIBBLES),
    .REC_W       (REC_W),
    .LINE_LEN    (LINE_LEN),
    .IDX_W       (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .fifoData (fifoData),
    .txOut    (txOut),
    .txActive (txActive),
    .frameDone(frameDone),
    .lastChar (lastChar),
    .charIdx  (charIdx)
  );

  assign fifoPop = ctl.loadRec;

endmodule

// File: rtl/ts_line_checker.sv
module ts_line_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEmpty,
  input logic             fifoPop,
  input logic             txOut,
  input logic             txActive,
  input logic [IDX_W-1:0] charIdx
);

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);                                  // R1

  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);                                    // R6

  AST_POP_LINE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (!txActive && txOut));                        // R6

  AST_POP_RESTARTS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> (charIdx == '0));                             // R2

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> !txOut);                              // R5

  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txActive) |-> ($past(txOut) && txOut));             // R5

endmodule

bind ts_line_serializer ts_line_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .fifoEmpty(fifoEmpty),
  .fifoPop  (fifoPop),
  .txOut    (txOut),
  .txActive (txActive),
  .charIdx  (charIdx)
);

// File: tb/sim_ts_line_serializer.sv
`timescale 1ns/1ps
module sim_ts_line_serializer;

  localparam int CPB      = 8;
  localparam int FRAME_N  = 10;
  localparam int LINE_N   = 16;
  localparam int WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoEmpty = 1'b1;
  logic [63:0] fifoData = '0;
  logic        fifoPop;
  logic        txOut;

  always #2.5 clk = ~clk;

  ts_line_serializer #(.CLKS_PER_BIT(CPB)) u0 (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .fifoData(fifoData),
    .fifoPop(fifoPop), .txOut(txOut)
  );

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [63:0] fifoQ[$];
  logic [7:0]  expQ[$];
  string       tagQ[$];

  int  rxBytes = 0;
  int  popsDone = 0;
  int  lineErrs = 0;
  bit  rxBusy = 1'b0;
  bit  popLatched = 1'b0;
  int  popWhileEmpty = 0;

  logic       smp [FRAME_N*CPB];
  logic [7:0] gotByte;
  logic [7:0] expByte;
  bit         frameOk;

  function automatic logic [7:0] expChar(input logic [63:0] r, input int p);
    logic [3:0] n;
    if (p < 7) begin
      n = r[32 + 4*(6-p) +: 4];
      return 8'h30 + {4'h0, n};
    end else if (p < 15) begin
      n = r[4*(14-p) +: 4];
      if (n < 4'd10) return 8'h30 + {4'h0, n};
      return 8'h41 + {4'h0, n} - 8'd10;
    end
    return 8'h0D;
  endfunction

  function automatic string posTag(input int p);
    if (p < 7)  return "R3";
    if (p < 15) return "R4";
    return "R2";
  endfunction

  task automatic pushRecord(input logic [63:0] r, input string tag);
    fifoQ.push_back(r);
    tagQ.push_back(tag);
    for (int p = 0; p < LINE_N; p++) expQ.push_back(expChar(r, p));
  endtask

  task automatic drain();
    while (expQ.size() != 0 || fifoQ.size() != 0) @(negedge clk);
    repeat (4*CPB) @(negedge clk);
  endtask

  task automatic checkIdle(input int n, input string what);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (txOut !== 1'b1 || fifoPop !== 1'b0) bad++;
    end
    total++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R1 %s: %0d idle cycles with activity, expected 0", what, bad);
    end
  endtask

  // FIFO model: pop registered at the edge, queue updated at the falling edge
  always @(posedge clk) popLatched <= rstN && fifoPop;

  always @(negedge clk) begin
    if (rstN && fifoPop && fifoEmpty) popWhileEmpty++;
    if (popLatched) begin
      total++;
      if (rxBusy || rxBytes != LINE_N*popsDone) begin
        fails++;
        $display("FAIL R6 pop with rxBusy=%0d bytes=%0d, expected idle with %0d bytes",
                 rxBusy, rxBytes, LINE_N*popsDone);
      end
      popsDone++;
      if (fifoQ.size() > 0) void'(fifoQ.pop_front());
    end
    fifoEmpty = (fifoQ.size() == 0);
    if (fifoQ.size() > 0) fifoData = fifoQ[0];
    else                  fifoData = {$urandom, $urandom};
  end

  // Serial receiver: samples every falling edge for one whole frame
  always begin
    @(negedge clk);
    if (rstN && txOut === 1'b0) begin
      rxBusy = 1'b1;
      smp[0] = txOut;
      for (int k = 1; k < FRAME_N*CPB; k++) begin
        @(negedge clk);
        smp[k] = txOut;
      end
      rxBusy = 1'b0;
      frameOk = 1'b1;
      for (int b = 0; b < FRAME_N; b++)
        for (int k = 1; k < CPB; k++)
          if (smp[b*CPB + k] !== smp[b*CPB]) frameOk = 1'b0;
      if (smp[0] !== 1'b0 || smp[(FRAME_N-1)*CPB] !== 1'b1) frameOk = 1'b0;
      for (int b = 0; b < 8; b++) gotByte[b] = smp[(b+1)*CPB + CPB/2];
      total++;
      if (!frameOk) begin
        fails++;
        $display("FAIL R5 frame for byte %02h: start=%b stop=%b, expected start=0 stop=1 and %0d-clock bits",
                 gotByte, smp[0], smp[(FRAME_N-1)*CPB], CPB);
      end
      total++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected byte %02h, expected none", gotByte);
      end else begin
        expByte = expQ.pop_front();
        if (gotByte !== expByte) begin
          fails++;
          lineErrs++;
          $display("FAIL %s char %0d got %02h expected %02h",
                   posTag(rxBytes % LINE_N), rxBytes % LINE_N, gotByte, expByte);
        end
      end
      rxBytes++;
      if (rxBytes % LINE_N == 0 && tagQ.size() > 0) begin
        string t;
        t = tagQ.pop_front();
        total++;
        if (lineErrs != 0) begin
          fails++;
          $display("FAIL %s line had %0d wrong chars, expected 0", t, lineErrs);
        end
        lineErrs = 0;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired: got hang, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int burst;
    logic [63:0] r;
    void'($urandom(32'd20111006));
    repeat (4) @(negedge clk);
    total++;
    if (txOut !== 1'b1 || fifoPop !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state txOut=%b pop=%b, expected 1/0", txOut, fifoPop);
    end
    @(negedge clk) rstN = 1'b1;
    checkIdle(40, "empty after reset");

    // directed lines
    @(posedge clk) #1;
    pushRecord({4'h0, 28'h0000000, 32'h00000000}, "R3");
    pushRecord({4'h0, 28'h1234567, 32'h89ABCDEF}, "R4");
    pushRecord({4'hF, 28'h9876543, 32'h0F1E2D3C}, "R7");
    pushRecord({4'hA, 28'hFAB0C9D, 32'hFFFFFFFF}, "R9");
    drain();
    checkIdle(50, "after directed lines");

    // single isolated record with a flipping top nibble
    @(posedge clk) #1;
    pushRecord({4'h5, 28'h0000001, 32'hA0000005}, "R7");
    drain();

    // random bursts with garbage on the bus between records
    for (int g = 0; g < 10; g++) begin
      burst = 1 + ($urandom % 4);
      for (int k = 0; k < burst; k++) begin
        r[63:60] = 4'($urandom);
        for (int d = 0; d < 7; d++) r[32 + 4*d +: 4] = 4'($urandom % 10);
        r[31:0] = $urandom;
        @(posedge clk) #1;
        pushRecord(r, "R8");
        repeat ($urandom % 300) @(posedge clk);
      end
      if (($urandom % 2) == 0) drain();
    end
    drain();
    checkIdle(200, "final idle");
    total++;
    if (popWhileEmpty != 0) begin
      fails++;
      $display("FAIL R1 pop while empty seen %0d times, expected 0", popWhileEmpty);
    end
    total++;
    if (rxBytes != LINE_N*popsDone) begin
      fails++;
      $display("FAIL R2 received %0d bytes, expected %0d", rxBytes, LINE_N*popsDone);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule